// File: doc/BRIEF.md
# Serial PCM Stereo Receiver

This block takes a stereo PCM stream made of a bit clock, a word clock and a serial data line, and turns it into parallel samples. All three serial lines are sampled as already-synchronised inputs on one system clock. Each received word appears on a 24-bit output bus with a flag that marks it left or right, and a one-cycle valid pulse.

At run time the block can select two framings: right-justified, where the word sits at the end of each half-period, and I2S, where the word starts one bit after the word-clock edge. It can select three word lengths and either word-clock polarity. These settings come from static configuration inputs and change only while the block is held in reset. A separate detector watches the data line and raises a flag once the data has stayed at zero for a long run of bit clocks.

Top module: `pcm_serial_rx`

## Requirements
- R1: Words arrive MSB first in two's complement; an N-bit word is sign-extended to the 24-bit sample output.
- R2: The 2-bit word-length code selects 16 bits (00), 20 bits (01) or 24 bits (10); the code 11 behaves as 16 bits.
- R3: In right-justified framing (cfg_i2s_i = 0) the word is the last N bits captured before a word-clock change. Bits earlier in the half-period are discarded. The sample is issued at the first bit-clock rise of the next half-period.
- R4: In I2S framing (cfg_i2s_i = 1) the bit at the first bit-clock rise after a word-clock change is skipped. The next N bits form the word, and any later bits in that half-period are ignored. The sample is issued at the rise that captures bit N.
- R5: With cfg_lr_swap_i = 0, word clock high carries the left channel (smp_left_o = 1) and word clock low carries the right. With cfg_lr_swap_i = 1 the two are exchanged.
- R6: smp_valid_o is a single-cycle pulse, one per channel word. No pulse is issued for a half-period that did not begin with a word-clock change seen after reset.
- R7: zero_flag_o rises one system clock after the bit-clock rise that completes a run of 65,536 consecutive zero data bits.
- R8: A data bit of one at any bit-clock rise clears the zero run and lowers zero_flag_o at that rise.
- R9: While in reset and just after it, smp_valid_o, smp_left_o, smp_data_o and zero_flag_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_i | input | 1 | Synchronised bit clock; data is taken on its rise |
| lrck_i | input | 1 | Synchronised word clock |
| sdata_i | input | 1 | Synchronised serial data |
| cfg_i2s_i | input | 1 | 0 = right-justified framing, 1 = I2S framing |
| cfg_lr_swap_i | input | 1 | Word-clock polarity select |
| cfg_wlen_i | input | 2 | Word-length code |
| smp_data_o | output | 24 | Sign-extended received sample |
| smp_left_o | output | 1 | 1 when the sample belongs to the left channel |
| smp_valid_o | output | 1 | One-cycle strobe for smp_data_o and smp_left_o |
| zero_flag_o | output | 1 | Long run of zero data detected |

## Verification
The assertions assume that the bit clock stays high and stays low for at least one system clock each, so every rise is detected exactly once. They also assume that the word clock and data change only together with the falling bit clock, and that configuration is held constant outside reset. The stimulus keeps to these rules. Each bit lasts two system clocks, the word clock and data move only on the cycle that lowers the bit clock, and configuration is loaded only while reset is held. Each half-period is 32 bits long, which leaves room for the 24-bit word and the I2S delay bit.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;
  localparam int SMP_W = 24;
  localparam int CNT_W = $clog2(SMP_W + 1);

  typedef enum logic [1:0] {
    WL_16  = 2'b00,
    WL_20  = 2'b01,
    WL_24  = 2'b10,
    WL_RSV = 2'b11
  } wlen_e;

  // Word length in bits for a configuration code; reserved acts as 16.
  function automatic logic [CNT_W-1:0] word_bits(input logic [1:0] code);
    case (wlen_e'(code))
      WL_20:   return CNT_W'(20);
      WL_24:   return CNT_W'(24);
      default: return CNT_W'(16);
    endcase
  endfunction

  // Keep the low nb bits of raw and copy bit nb-1 into the bits above.
  function automatic logic [SMP_W-1:0] sext(input logic [SMP_W-1:0] raw,
                                            input logic [CNT_W-1:0] nb);
    logic [SMP_W-1:0] res;
    logic             sgn;
    sgn = raw[nb - CNT_W'(1)];
    for (int i = 0; i < SMP_W; i++) begin
      res[i] = (i < int'(nb)) ? raw[i] : sgn;
    end
    return res;
  endfunction
endpackage

// File: rtl/pcm_rx_edge.sv
module pcm_rx_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_i,
  input  logic lrck_i,
  input  logic sdata_i,
  output logic bit_rise,
  output logic bit_val,
  output logic lr_val
);
  logic bclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) bclk_q <= 1'b0;
    else        bclk_q <= bclk_i;
  end

  assign bit_rise = bclk_i & ~bclk_q;
  assign bit_val  = sdata_i;
  assign lr_val   = lrck_i;
endmodule

// File: rtl/pcm_rx_framer.sv
module pcm_rx_framer
  import pcm_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_rise,
  input  logic             bit_val,
  input  logic             lr_val,
  input  logic             cfg_i2s,
  input  logic             cfg_swap,
  input  logic [CNT_W-1:0] nbits,
  output logic [SMP_W-1:0] smp_data,
  output logic             smp_left,
  output logic             smp_valid
);
  logic             seen_q, armed_q, lr_prev_q, collect_q;
  logic [SMP_W-1:0] shreg_q;
  logic [CNT_W-1:0] bitcnt_q;

  logic             lr_change;
  logic [SMP_W-1:0] shifted;
  logic             emit_rj;
  logic             emit_i2s;

  always_comb begin
    lr_change = seen_q && (lr_val != lr_prev_q);
    shifted   = {shreg_q[SMP_W-2:0], bit_val};
    emit_rj   = !cfg_i2s && lr_change && armed_q;
    emit_i2s  = cfg_i2s && !lr_change && collect_q &&
                (bitcnt_q == nbits - CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q    <= 1'b0;
      armed_q   <= 1'b0;
      lr_prev_q <= 1'b0;
      collect_q <= 1'b0;
      shreg_q   <= '0;
      bitcnt_q  <= '0;
      smp_data  <= '0;
      smp_left  <= 1'b0;
      smp_valid <= 1'b0;
    end else begin
      smp_valid <= 1'b0;
      if (bit_rise) begin
        seen_q    <= 1'b1;
        lr_prev_q <= lr_val;
        shreg_q   <= shifted;
        if (lr_change) armed_q <= 1'b1;
        // Right-justified: the word ended on the previous rise.
        if (emit_rj) begin
          smp_data  <= sext(shreg_q, nbits);
          smp_left  <= lr_prev_q ^ cfg_swap;
          smp_valid <= 1'b1;
        end
        // I2S: skip the delay bit, then count the word in.
        if (cfg_i2s) begin
          if (lr_change) begin
            bitcnt_q  <= '0;
            collect_q <= 1'b1;
          end else if (collect_q) begin
            bitcnt_q <= bitcnt_q + CNT_W'(1);
            if (emit_i2s) begin
              collect_q <= 1'b0;
              smp_data  <= sext(shifted, nbits);
              smp_left  <= lr_val ^ cfg_swap;
              smp_valid <= 1'b1;
            end
          end
        end
      end
    end
  end

  assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> !smp_valid);
  assert_valid_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> $past(bit_rise));
  assert_i2s_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_i2s && collect_q) |-> (bitcnt_q < nbits));
  assert_rj_needs_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !cfg_i2s) |-> $past(lr_val != lr_prev_q));
endmodule

// File: rtl/pcm_rx_zero_det.sv
module pcm_rx_zero_det #(
  parameter int ZERO_RUN = 65536,
  localparam int ZW = $clog2(ZERO_RUN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_rise,
  input  logic bit_val,
  output logic zero_flag
);
  logic [ZW-1:0] run_q;
  logic          run_full;

  assign run_full = (run_q == ZW'(ZERO_RUN));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q     <= '0;
      zero_flag <= 1'b0;
    end else if (bit_rise) begin
      if (bit_val) begin
        run_q     <= '0;
        zero_flag <= 1'b0;
      end else if (!run_full) begin
        run_q <= run_q + ZW'(1);
        if (run_q == ZW'(ZERO_RUN - 1)) zero_flag <= 1'b1;
      end
    end
  end

  assert_flag_rise_on_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(zero_flag) |-> $past(bit_rise && !bit_val));
  assert_flag_fall_on_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(zero_flag) |-> $past(bit_rise && bit_val));
  assert_flag_full_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    zero_flag |-> run_full);
endmodule

// File: rtl/pcm_serial_rx.sv
module pcm_serial_rx
  import pcm_rx_pkg::*;
#(
  parameter int ZERO_RUN = 65536
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bclk_i,
  input  logic             lrck_i,
  input  logic             sdata_i,
  input  logic             cfg_i2s_i,
  input  logic             cfg_lr_swap_i,
  input  logic [1:0]       cfg_wlen_i,
  output logic [SMP_W-1:0] smp_data_o,
  output logic             smp_left_o,
  output logic             smp_valid_o,
  output logic             zero_flag_o
);
  logic             bit_rise;
  logic             bit_val;
  logic             lr_val;
  logic [CNT_W-1:0] nbits;

  assign nbits = word_bits(cfg_wlen_i);

  pcm_rx_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .bclk_i   (bclk_i),
    .lrck_i   (lrck_i),
    .sdata_i  (sdata_i),
    .bit_rise (bit_rise),
    .bit_val  (bit_val),
    .lr_val   (lr_val)
  );

  pcm_rx_framer u_framer (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_rise  (bit_rise),
    .bit_val   (bit_val),
    .lr_val    (lr_val),
    .cfg_i2s   (cfg_i2s_i),
    .cfg_swap  (cfg_lr_swap_i),
    .nbits     (nbits),
    .smp_data  (smp_data_o),
    .smp_left  (smp_left_o),
    .smp_valid (smp_valid_o)
  );

  pcm_rx_zero_det #(.ZERO_RUN(ZERO_RUN)) u_zero (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_rise  (bit_rise),
    .bit_val   (bit_val),
    .zero_flag (zero_flag_o)
  );

  // Above the word's sign bit every output bit must match it.
  logic signed [SMP_W-1:0] sign_span;
  assign sign_span = $signed(smp_data_o) >>> (nbits - CNT_W'(1));

  assert_sign_extended_R1: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid_o |-> (sign_span == '0 || sign_span == '1));
  assert_reserved_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wlen_i == 2'b11) |-> (nbits == CNT_W'(16)));
endmodule

// File: tb/pcm_serial_rx_tb_top.sv
`timescale 1ns/1ps
module pcm_serial_rx_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk = 1'b0, lrck = 1'b0, sdata = 1'b0;
  logic        cfg_i2s = 1'b0, cfg_swap = 1'b0;
  logic [1:0]  cfg_wlen = 2'b00;
  logic [23:0] smp_data;
  logic        smp_left, smp_valid, zero_flag;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [23:0] cap_d [4];
  logic        cap_l [4];
  int          cap_n = 0;

  always #2.5 clk = ~clk;

  pcm_serial_rx dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .bclk_i        (bclk),
    .lrck_i        (lrck),
    .sdata_i       (sdata),
    .cfg_i2s_i     (cfg_i2s),
    .cfg_lr_swap_i (cfg_swap),
    .cfg_wlen_i    (cfg_wlen),
    .smp_data_o    (smp_data),
    .smp_left_o    (smp_left),
    .smp_valid_o   (smp_valid),
    .zero_flag_o   (zero_flag)
  );

  // {i2s, swap, wlen[1:0], left[23:0], right[23:0]}
  localparam logic [51:0] VECS [8] = '{
    {1'b0, 1'b0, 2'b00, 24'h008001, 24'h007ffe},
    {1'b0, 1'b1, 2'b01, 24'h080000, 24'h012345},
    {1'b0, 1'b0, 2'b10, 24'h800001, 24'h7fffff},
    {1'b0, 1'b0, 2'b11, 24'habcdef, 24'h001234},
    {1'b1, 1'b0, 2'b00, 24'h00a5a5, 24'h005a5a},
    {1'b1, 1'b1, 2'b01, 24'hfffff1, 24'h076543},
    {1'b1, 1'b0, 2'b10, 24'hc00000, 24'h000001},
    {1'b1, 1'b1, 2'b11, 24'h123456, 24'hff8000}
  };

  always @(negedge clk) begin
    if (rst_n && smp_valid && cap_n < 4) begin
      cap_d[cap_n] = smp_data;
      cap_l[cap_n] = smp_left;
      cap_n = cap_n + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int ref_len(input logic [1:0] code);
    if (code == 2'b01) return 20;
    if (code == 2'b10) return 24;
    return 16;
  endfunction

  function automatic logic [23:0] ref_ext(input logic [23:0] v, input int n);
    logic [23:0] m;
    m = (24'h1 << n) - 24'h1;
    if (v[n-1]) return (v & m) | ~m;
    return v & m;
  endfunction

  task automatic do_reset(input logic i2s, input logic swp, input logic [1:0] wl);
    @(negedge clk);
    rst_n = 1'b0; bclk = 1'b0; sdata = 1'b0;
    cfg_i2s = i2s; cfg_swap = swp; cfg_wlen = wl;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic drive_bit(input logic lr, input logic b);
    @(negedge clk);
    bclk = 1'b0; lrck = lr; sdata = b;
    @(negedge clk);
    bclk = 1'b1;
  endtask

  task automatic send_half(input logic lr, input logic i2s, input logic [23:0] w, input int n);
    for (int k = 0; k < 32; k++) begin
      logic b;
      if (!i2s) b = (k < 32 - n) ? 1'b1 : w[31-k];
      else      b = (k >= 1 && k <= n) ? w[n-k] : 1'b1;
      drive_bit(lr, b);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog cycles=%0d expected below 190000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    do_reset(1'b0, 1'b0, 2'b00);
    @(posedge clk); #1;
    chk("R9 valid after reset", 32'(smp_valid), 32'h0);
    chk("R9 data after reset", 32'(smp_data), 32'h0);
    chk("R9 left after reset", 32'(smp_left), 32'h0);
    chk("R9 zero flag after reset", 32'(zero_flag), 32'h0);

    // Vector walk: R1 R2 R3 R4 R5 R6
    for (int v = 0; v < 8; v++) begin
      logic        i2s, swp, ll;
      logic [1:0]  wl;
      logic [23:0] lw, rw;
      int          n;
      string       mt;
      {i2s, swp, wl, lw, rw} = VECS[v];
      n  = ref_len(wl);
      ll = ~swp;
      mt = i2s ? "R4" : "R3";
      do_reset(i2s, swp, wl);
      cap_n = 0;
      for (int k = 0; k < 4; k++) drive_bit(~ll, 1'b1);
      send_half(ll, i2s, lw, n);
      send_half(~ll, i2s, rw, n);
      drive_bit(ll, 1'b1);
      drive_bit(ll, 1'b1);
      repeat (3) @(negedge clk);
      chk($sformatf("R6 vec%0d sample count", v), 32'(cap_n), 32'd2);
      chk($sformatf("%s R1 R2 vec%0d left data", mt, v), 32'(cap_d[0]), 32'(ref_ext(lw, n)));
      chk($sformatf("R5 vec%0d first is left", v), 32'(cap_l[0]), 32'h1);
      chk($sformatf("%s R1 R2 vec%0d right data", mt, v), 32'(cap_d[1]), 32'(ref_ext(rw, n)));
      chk($sformatf("R5 vec%0d second is right", v), 32'(cap_l[1]), 32'h0);
    end

    // R7 / R8: zero-run detector
    do_reset(1'b0, 1'b0, 2'b00);
    drive_bit(1'b1, 1'b1);
    for (int k = 0; k < 65535; k++) drive_bit(1'b1, 1'b0);
    @(posedge clk); #1;
    chk("R7 flag low after 65535 zeros", 32'(zero_flag), 32'h0);
    drive_bit(1'b1, 1'b0);
    @(posedge clk); #1;
    chk("R7 flag high after 65536 zeros", 32'(zero_flag), 32'h1);
    drive_bit(1'b1, 1'b0);
    @(posedge clk); #1;
    chk("R7 flag holds on further zeros", 32'(zero_flag), 32'h1);
    drive_bit(1'b1, 1'b1);
    @(posedge clk); #1;
    chk("R8 flag cleared by one bit", 32'(zero_flag), 32'h0);
    drive_bit(1'b1, 1'b0);
    @(posedge clk); #1;
    chk("R8 run restarts from zero", 32'(zero_flag), 32'h0);
    chk("R6 no samples without word clock change", 32'(smp_valid), 32'h0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule